// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is the shifting core of a master-only SPI port. It takes transmit words from an external show-ahead FIFO, drives SCK, MOSI and samples MISO, and hands received data to an external receive FIFO. It produces no chip selects. Word length, bit order, clock polarity, clock phase, the level MOSI rests at, and a 16-bit half-period reload value come in on static configuration inputs. These inputs must hold steady while `busy` is high.

The transmit and receive paths can each be switched off. With transmit on, one word is shifted for every FIFO entry. With transmit off and receive on, the engine clocks nothing until a nonzero byte count is loaded into its receive request counter. It then clocks exactly that many 8-bit units, and `todo` reports how many remain. Received bits are collected into bytes and packed four to a 32-bit FIFO entry. A short final entry carries its own valid-byte count.

Top module: `spi_ser_engine`

## Requirements
- R1: SCK rests at `cfg_cpol` while idle. While shifting, SCK toggles every `cfg_reload`+1 clock cycles, so one SCK period lasts 2·(`cfg_reload`+1) cycles.
- R2: `cfg_word_m1` holds the word length minus one, so words have 1 to 32 bits. A word of N bits keeps `busy` high for exactly 2·N·(`cfg_reload`+1) cycles.
- R3: With `cfg_msb_first`=1, bit N-1 of the word goes out first. With it 0, bit 0 goes out first. The same order applies to received bits.
- R4: With `cfg_ph_lead`=1, the first bit is on MOSI before the first SCK edge. MISO is then sampled on leading edges and MOSI changes on trailing edges. With `cfg_ph_lead`=0, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R5: MOSI equals `cfg_idle_mosi` whenever no word is being shifted. It also holds that level throughout receive-only operation.
- R6: With `cfg_tx_off`=1 and `cfg_rx_off`=0, no SCK edge occurs while `todo` is 0. A request of K bytes produces exactly 8·K SCK pulses, and `todo` drops by one after each byte.
- R7: A write on `rxreq_we` is ignored while `todo` is nonzero or when `rxreq_cnt` is 0.
- R8: Received bytes are packed with the earliest byte in the most significant position of the filled bytes. An entry is pushed with `rxf_nbytes`=4 as soon as four bytes are complete.
- R9: At the end of a transfer, any incomplete entry is pushed right-aligned with `rxf_nbytes` in 1..3. The end of a transfer is the last word with the transmit FIFO empty, or the last requested byte. A trailing partial byte occupies its low bit positions and counts as one byte.
- R10: Each transmitted word pops the transmit FIFO exactly once. With `cfg_tx_off`=1 nothing is popped, and with `cfg_rx_off`=1 nothing is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word_m1 | input | 5 | Word length minus one |
| cfg_msb_first | input | 1 | 1: MSB first, 0: LSB first |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_ph_lead | input | 1 | 1: sample on leading edge, 0: sample on trailing edge |
| cfg_idle_mosi | input | 1 | MOSI level when not shifting |
| cfg_tx_off | input | 1 | Transmit path disabled |
| cfg_rx_off | input | 1 | Receive path disabled |
| cfg_reload | input | 16 | SCK half-period reload value |
| rxreq_we | input | 1 | Load a receive byte request |
| rxreq_cnt | input | 16 | Requested byte count |
| todo | output | 16 | Requested bytes still to clock |
| busy | output | 1 | Word in progress |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_data | input | 32 | Head entry of the transmit FIFO |
| txf_pop | output | 1 | Remove the head transmit entry |
| rxf_push | output | 1 | Write an entry into the receive FIFO |
| rxf_data | output | 32 | Packed receive entry |
| rxf_nbytes | output | 3 | Valid bytes in the pushed entry |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions rely on three assumptions:
- The configuration inputs stay constant while `busy` is high.
- The transmit FIFO presents its head entry combinationally and retires it one cycle after `txf_pop`.
- The receive side never back-pressures a push.

The bench changes configuration only between scenarios, after the engine has stayed idle for several cycles. Its FIFO model retires entries on the clock edge that sees `txf_pop` and accepts every push. Its serial slave either loops MOSI back or changes MISO on the edge opposite the sampling edge.

// File: rtl/spi_ser_pkg.sv
package spi_ser_pkg;
  typedef enum logic {ST_IDLE, ST_SHIFT} eng_st_t;
endpackage

// File: rtl/spi_ser_baud.sv
module spi_ser_baud #(
  parameter int BRW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic [BRW-1:0] reload,
  output logic           tick
);
  logic [BRW-1:0] cnt_q;

  // one tick per SCK half period while running
  assign tick = run && (cnt_q == reload);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_ser_rxpack.sv
module spi_ser_rxpack #(
  parameter int DW  = 32,
  parameter int NBW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bit_vld,
  input  logic           bit_in,
  input  logic           msb_first,
  input  logic           flush,
  output logic           push,
  output logic [DW-1:0]  data,
  output logic [NBW-1:0] nbytes
);
  localparam int NB = DW / 8;

  logic [7:0]     byte_q, byte_n;
  logic [2:0]     pos_q, pos_n;
  logic [DW-1:0]  ent_q, ent_a, ent_b;
  logic [NBW-1:0] cnt_q, cnt_a, cnt_b;
  logic           full_byte, part, do_push;

  always_comb begin
    byte_n = byte_q;
    if (bit_vld) begin
      if (msb_first) byte_n = {byte_q[6:0], bit_in};
      else           byte_n[pos_q] = bit_in;
    end
    pos_n     = pos_q + {2'b00, bit_vld};
    full_byte = bit_vld && (pos_q == 3'd7);
    ent_a     = full_byte ? {ent_q[DW-9:0], byte_n} : ent_q;
    cnt_a     = cnt_q + NBW'(full_byte);
    // a partial trailing byte is appended at flush time
    part      = flush && (pos_n != 3'd0);
    ent_b     = part ? {ent_a[DW-9:0], byte_n} : ent_a;
    cnt_b     = cnt_a + NBW'(part);
    do_push   = (cnt_b == NBW'(NB)) || (flush && (cnt_b != '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= '0;
      pos_q  <= '0;
      ent_q  <= '0;
      cnt_q  <= '0;
      push   <= 1'b0;
      data   <= '0;
      nbytes <= '0;
    end else begin
      push <= do_push;
      if (do_push) begin
        data   <= ent_b;
        nbytes <= cnt_b;
      end
      ent_q  <= (do_push || flush) ? '0 : ent_b;
      cnt_q  <= (do_push || flush) ? '0 : cnt_b;
      byte_q <= (full_byte || flush) ? 8'd0 : byte_n;
      pos_q  <= flush ? 3'd0 : pos_n;
    end
  end
endmodule

// File: rtl/spi_ser_engine.sv
module spi_ser_engine
  import spi_ser_pkg::*;
#(
  parameter int DW     = 32,
  parameter int BRW    = 16,
  parameter int TODO_W = 16,
  parameter int LEN_W  = $clog2(DW),
  parameter int NBW    = $clog2(DW / 8) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  cfg_word_m1,
  input  logic              cfg_msb_first,
  input  logic              cfg_cpol,
  input  logic              cfg_ph_lead,
  input  logic              cfg_idle_mosi,
  input  logic              cfg_tx_off,
  input  logic              cfg_rx_off,
  input  logic [BRW-1:0]    cfg_reload,
  input  logic              rxreq_we,
  input  logic [TODO_W-1:0] rxreq_cnt,
  output logic [TODO_W-1:0] todo,
  output logic              busy,
  input  logic              txf_empty,
  input  logic [DW-1:0]     txf_data,
  output logic              txf_pop,
  output logic              rxf_push,
  output logic [DW-1:0]     rxf_data,
  output logic [NBW-1:0]    rxf_nbytes,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  eng_st_t           st_q;
  logic              lead_q, cpha0_q, msb_q, rxonly_q, rxen_q;
  logic [LEN_W-1:0]  nm1_q, bidx_q;
  logic [DW-1:0]     txsh_q;
  logic [TODO_W-1:0] todo_q;
  logic              sck_q, mosi_q, pop_q;

  logic              tick, go_tx, go_rx, edge_lead, edge_trail, last;
  logic              word_end, smp, drive, flush, req_ok, head;
  logic [LEN_W-1:0]  sh_amt;
  logic [DW-1:0]     aligned;

  spi_ser_baud #(.BRW(BRW)) u_baud (
    .clk(clk), .rst(rst), .run(st_q == ST_SHIFT), .reload(cfg_reload), .tick(tick)
  );

  always_comb begin
    go_tx      = !cfg_tx_off && !txf_empty;
    go_rx      = cfg_tx_off && !cfg_rx_off && (todo_q != '0);
    sh_amt     = LEN_W'(DW - 1) - cfg_word_m1;
    aligned    = cfg_msb_first ? (txf_data << sh_amt) : txf_data;
    head       = msb_q ? txsh_q[DW-1] : txsh_q[0];
    edge_lead  = tick && !lead_q;
    edge_trail = tick && lead_q;
    last       = (bidx_q == nm1_q);
    word_end   = edge_trail && last;
    smp        = rxen_q && ((edge_lead && cpha0_q) || (edge_trail && !cpha0_q));
    drive      = !rxonly_q && ((edge_lead && !cpha0_q) || (edge_trail && cpha0_q && !last));
    flush      = word_end && (rxonly_q ? (todo_q == TODO_W'(1)) : txf_empty);
    req_ok     = rxreq_we && (todo_q == '0) && (rxreq_cnt != '0);
  end

  spi_ser_rxpack #(.DW(DW), .NBW(NBW)) u_pack (
    .clk(clk), .rst(rst), .bit_vld(smp), .bit_in(miso), .msb_first(msb_q),
    .flush(flush && rxen_q), .push(rxf_push), .data(rxf_data), .nbytes(rxf_nbytes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      lead_q   <= 1'b0;
      cpha0_q  <= 1'b0;
      msb_q    <= 1'b0;
      rxonly_q <= 1'b0;
      rxen_q   <= 1'b0;
      nm1_q    <= '0;
      bidx_q   <= '0;
      txsh_q   <= '0;
      todo_q   <= '0;
      sck_q    <= cfg_cpol;
      mosi_q   <= cfg_idle_mosi;
      pop_q    <= 1'b0;
    end else begin
      pop_q <= 1'b0;
      if (req_ok)                    todo_q <= rxreq_cnt;
      else if (word_end && rxonly_q) todo_q <= todo_q - 1'b1;
      case (st_q)
        ST_IDLE: begin
          sck_q  <= cfg_cpol;
          mosi_q <= cfg_idle_mosi;
          if (go_tx || go_rx) begin
            st_q     <= ST_SHIFT;
            lead_q   <= 1'b0;
            bidx_q   <= '0;
            nm1_q    <= go_tx ? cfg_word_m1 : LEN_W'(7);
            rxonly_q <= go_rx;
            rxen_q   <= !cfg_rx_off;
            msb_q    <= cfg_msb_first;
            cpha0_q  <= cfg_ph_lead;
            pop_q    <= go_tx;
            if (go_tx && cfg_ph_lead) begin
              mosi_q <= cfg_msb_first ? aligned[DW-1] : aligned[0];
              txsh_q <= cfg_msb_first ? (aligned << 1) : (aligned >> 1);
            end else begin
              txsh_q <= go_tx ? aligned : '0;
            end
          end
        end
        default: begin
          if (tick) begin
            sck_q  <= ~sck_q;
            lead_q <= ~lead_q;
            if (drive) begin
              mosi_q <= head;
              txsh_q <= msb_q ? (txsh_q << 1) : (txsh_q >> 1);
            end
            if (edge_trail) begin
              if (last) begin
                st_q   <= ST_IDLE;
                mosi_q <= cfg_idle_mosi;
              end else begin
                bidx_q <= bidx_q + 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

  assign todo    = todo_q;
  assign busy    = (st_q == ST_SHIFT);
  assign txf_pop = pop_q;
  assign sck     = sck_q;
  assign mosi    = mosi_q;
endmodule

// File: rtl/spi_ser_chk.sv
module spi_ser_chk #(
  parameter int DW     = 32,
  parameter int TODO_W = 16,
  parameter int NBW    = $clog2(DW / 8) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              sck,
  input logic              mosi,
  input logic              cfg_cpol,
  input logic              cfg_idle_mosi,
  input logic              cfg_tx_off,
  input logic [TODO_W-1:0] todo,
  input logic              txf_pop,
  input logic              rxf_push,
  input logic [NBW-1:0]    rxf_nbytes
);
  a_r1_sck_rests: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cfg_cpol)) |-> (sck == cfg_cpol));

  a_r5_mosi_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> (mosi == $past(cfg_idle_mosi)));

  a_r5_rxonly_mosi: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_tx_off) |-> (mosi == cfg_idle_mosi));

  a_r6_no_request_no_clock: assert property (@(posedge clk) disable iff (rst)
    (todo == '0 && cfg_tx_off && !busy) |=> !busy);

  a_r7_todo_step: assert property (@(posedge clk) disable iff (rst)
    ($past(todo) != '0 && todo != $past(todo)) |-> (todo == $past(todo) - TODO_W'(1)));

  a_r8_push_count: assert property (@(posedge clk) disable iff (rst)
    rxf_push |-> (rxf_nbytes != '0 && rxf_nbytes <= NBW'(DW / 8)));

  a_r10_single_pop: assert property (@(posedge clk) disable iff (rst)
    txf_pop |=> !txf_pop);

  a_r10_pop_in_word: assert property (@(posedge clk) disable iff (rst)
    txf_pop |-> busy);
endmodule

bind spi_ser_engine spi_ser_chk #(.DW(DW), .TODO_W(TODO_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .sck(sck), .mosi(mosi),
  .cfg_cpol(cfg_cpol), .cfg_idle_mosi(cfg_idle_mosi), .cfg_tx_off(cfg_tx_off),
  .todo(todo), .txf_pop(txf_pop), .rxf_push(rxf_push), .rxf_nbytes(rxf_nbytes)
);

// File: tb/tb_spi_ser_engine.sv
module tb_spi_ser_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] cfg_word_m1 = 5'd7;
  logic cfg_msb_first = 1'b1, cfg_cpol = 1'b0, cfg_ph_lead = 1'b1, cfg_idle_mosi = 1'b1;
  logic cfg_tx_off = 1'b0, cfg_rx_off = 1'b0;
  logic [15:0] cfg_reload = 16'd1;
  logic rxreq_we = 1'b0;
  logic [15:0] rxreq_cnt = '0;
  logic [15:0] todo;
  logic busy, txf_pop, rxf_push, sck, mosi, miso;
  logic [31:0] rxf_data;
  logic [2:0] rxf_nbytes;

  logic [31:0] txq [0:15];
  int rd = 0, wr = 0;
  logic txf_empty;
  logic [31:0] txf_data;
  assign txf_empty = (rd == wr);
  assign txf_data  = txq[rd[3:0]];

  logic loop = 1'b1, miso_s = 1'b0, slv_on = 1'b0;
  logic [7:0] slv_bytes [0:7];
  int sidx = 0;
  assign miso = loop ? mosi : miso_s;

  int nchk = 0, nerr = 0;
  int cyc = 0, pops = 0, rises = 0, last_rise = 0, last_per = 0, busy_cyc = 0, mosi_bad = 0;
  logic [31:0] rxd [0:31];
  logic [2:0]  rxn [0:31];
  int rxc = 0;
  bit done = 0;

  spi_ser_engine dut (
    .clk(clk), .rst(rst), .cfg_word_m1(cfg_word_m1), .cfg_msb_first(cfg_msb_first),
    .cfg_cpol(cfg_cpol), .cfg_ph_lead(cfg_ph_lead), .cfg_idle_mosi(cfg_idle_mosi),
    .cfg_tx_off(cfg_tx_off), .cfg_rx_off(cfg_rx_off), .cfg_reload(cfg_reload),
    .rxreq_we(rxreq_we), .rxreq_cnt(rxreq_cnt), .todo(todo), .busy(busy),
    .txf_empty(txf_empty), .txf_data(txf_data), .txf_pop(txf_pop),
    .rxf_push(rxf_push), .rxf_data(rxf_data), .rxf_nbytes(rxf_nbytes),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (busy) busy_cyc = busy_cyc + 1;
    if (busy && cfg_tx_off && (mosi != cfg_idle_mosi)) mosi_bad = mosi_bad + 1;
    if (!rst && txf_pop) begin
      rd <= rd + 1;
      pops = pops + 1;
    end
    if (!rst && rxf_push) begin
      rxd[rxc] = rxf_data;
      rxn[rxc] = rxf_nbytes;
      rxc = rxc + 1;
    end
  end

  always @(posedge sck) begin
    rises = rises + 1;
    last_per = cyc - last_rise;
    last_rise = cyc;
    if (slv_on) begin
      miso_s = slv_bytes[sidx / 8][7 - (sidx % 8)];
      sidx = sidx + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
  endtask

  task automatic push_word(input logic [31:0] w);
    txq[wr[3:0]] = w;
    wr = wr + 1;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int i = 0; i < 20000 && quiet < 4; i++) begin
      @(negedge clk);
      if (!busy && rd == wr && todo == 0) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R2 reset busy", busy, 0);
    chk(sck == 1'b0, "R1 reset sck", sck, 0);
    chk(mosi == 1'b1, "R5 reset mosi", mosi, 1);
    chk(todo == 16'd0, "R6 reset todo", todo, 0);
  endtask

  // 8-bit MSB first, leading-edge sampling, reload 1, loopback
  task automatic t_duplex8();
    int rb = rxc, pb = pops, bb = busy_cyc;
    @(negedge clk);
    cfg_word_m1 = 5'd7; cfg_msb_first = 1; cfg_cpol = 0; cfg_ph_lead = 1; cfg_reload = 16'd1;
    push_word(32'hA5); push_word(32'h3C);
    wait_idle();
    chk(last_per == 4, "R1 sck period", last_per, 4);
    chk(busy_cyc - bb == 64, "R2 busy cycles 8-bit", busy_cyc - bb, 64);
    chk(pops - pb == 2, "R10 pops per word", pops - pb, 2);
    chk(rxc - rb == 1, "R9 push count", rxc - rb, 1);
    chk(rxd[rb] == 32'h0000A53C, "R9 partial entry data", rxd[rb], 32'h0000A53C);
    chk(rxn[rb] == 3'd2, "R9 partial entry count", rxn[rb], 2);
  endtask

  // 12-bit LSB first, trailing-edge sampling, idle-high clock, reload 0
  task automatic t_lsb12();
    int rb = rxc, bb = busy_cyc;
    @(negedge clk);
    cfg_word_m1 = 5'd11; cfg_msb_first = 0; cfg_cpol = 1; cfg_ph_lead = 0; cfg_reload = 16'd0;
    repeat (2) @(negedge clk);
    push_word(32'h00000ABC);
    wait_idle();
    chk(busy_cyc - bb == 24, "R2 busy cycles 12-bit", busy_cyc - bb, 24);
    chk(last_per == 2, "R1 sck period reload 0", last_per, 2);
    chk(rxd[rb] == 32'h0000BC0A, "R3 lsb-first packing", rxd[rb], 32'h0000BC0A);
    chk(rxn[rb] == 3'd2, "R9 partial byte counted", rxn[rb], 2);
    chk(sck == 1'b1, "R4 sck idle high", sck, 1);
  endtask

  // two 32-bit words fill two full entries
  task automatic t_full32();
    int rb = rxc;
    @(negedge clk);
    cfg_word_m1 = 5'd31; cfg_msb_first = 1; cfg_cpol = 0; cfg_ph_lead = 1; cfg_reload = 16'd1;
    repeat (2) @(negedge clk);
    push_word(32'hDEADBEEF); push_word(32'h01234567);
    wait_idle();
    chk(rxc - rb == 2, "R8 full entries count", rxc - rb, 2);
    chk(rxd[rb] == 32'hDEADBEEF, "R8 first entry", rxd[rb], 32'hDEADBEEF);
    chk(rxn[rb] == 3'd4, "R8 first entry count", rxn[rb], 4);
    chk(rxd[rb+1] == 32'h01234567, "R8 second entry", rxd[rb+1], 32'h01234567);
  endtask

  // 1-bit words
  task automatic t_bit1();
    int rb = rxc, bb = busy_cyc;
    @(negedge clk);
    cfg_word_m1 = 5'd0; cfg_msb_first = 1; cfg_reload = 16'd1;
    push_word(32'h1); push_word(32'h0); push_word(32'h1);
    wait_idle();
    chk(busy_cyc - bb == 12, "R2 one-bit words", busy_cyc - bb, 12);
    chk(rxd[rb] == 32'h05 && rxn[rb] == 3'd1, "R9 one partial byte", rxd[rb], 32'h05);
  endtask

  // receive off: words go out, nothing pushed
  task automatic t_rxoff();
    int rb = rxc, pb = pops;
    @(negedge clk);
    cfg_word_m1 = 5'd7; cfg_rx_off = 1;
    push_word(32'h5A);
    wait_idle();
    chk(pops - pb == 1, "R10 pop with rx off", pops - pb, 1);
    chk(rxc - rb == 0, "R10 no push with rx off", rxc - rb, 0);
    cfg_rx_off = 0;
  endtask

  // both paths off: FIFO untouched, no clock
  task automatic t_alloff();
    int pb = pops, sb = rises;
    @(negedge clk);
    cfg_tx_off = 1; cfg_rx_off = 1;
    push_word(32'hFF);
    repeat (100) @(negedge clk);
    chk(pops - pb == 0, "R10 no pop with tx off", pops - pb, 0);
    chk(rises - sb == 0 && !busy, "R6 no clock with both off", rises - sb, 0);
    rd = wr;
    cfg_rx_off = 0;
  endtask

  // receive-only by byte request
  task automatic t_rxonly();
    int rb = rxc, sb, mb = mosi_bad;
    @(negedge clk);
    cfg_tx_off = 1; cfg_rx_off = 0; cfg_ph_lead = 0; cfg_cpol = 0; cfg_msb_first = 1;
    cfg_reload = 16'd1; cfg_idle_mosi = 1; loop = 0;
    slv_bytes[0] = 8'h11; slv_bytes[1] = 8'h22; slv_bytes[2] = 8'h33;
    slv_bytes[3] = 8'h44; slv_bytes[4] = 8'h55;
    sidx = 0; slv_on = 1;
    sb = rises;
    repeat (50) @(negedge clk);
    chk(rises - sb == 0, "R6 no clock before request", rises - sb, 0);
    rxreq_cnt = 16'd0; rxreq_we = 1;
    @(negedge clk);
    rxreq_we = 0;
    @(negedge clk);
    chk(todo == 16'd0 && !busy, "R7 zero request ignored", todo, 0);
    rxreq_cnt = 16'd5; rxreq_we = 1;
    @(negedge clk);
    rxreq_we = 0;
    repeat (2) @(negedge clk);
    rxreq_cnt = 16'd9; rxreq_we = 1;
    @(negedge clk);
    rxreq_we = 0;
    repeat (2) @(negedge clk);
    chk(todo == 16'd5, "R7 request ignored while pending", todo, 5);
    wait_idle();
    chk(rises - sb == 40, "R6 clocks per requested bytes", rises - sb, 40);
    chk(todo == 16'd0, "R6 todo drained", todo, 0);
    chk(mosi_bad - mb == 0, "R5 mosi idle in receive-only", mosi_bad - mb, 0);
    chk(rxc - rb == 2, "R8 receive-only entries", rxc - rb, 2);
    chk(rxd[rb] == 32'h11223344 && rxn[rb] == 3'd4, "R8 receive-only full entry", rxd[rb], 32'h11223344);
    chk(rxd[rb+1] == 32'h55 && rxn[rb+1] == 3'd1, "R9 receive-only tail", rxd[rb+1], 32'h55);
    slv_on = 0; loop = 1; cfg_tx_off = 0; cfg_ph_lead = 1;
  endtask

  task automatic t_idle_low();
    @(negedge clk);
    cfg_idle_mosi = 0;
    repeat (3) @(negedge clk);
    chk(mosi == 1'b0, "R5 idle level low", mosi, 0);
    cfg_idle_mosi = 1;
    repeat (3) @(negedge clk);
    chk(mosi == 1'b1, "R5 idle level high", mosi, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_duplex8();
    t_lsb12();
    t_full32();
    t_bit1();
    t_rxoff();
    t_alloff();
    t_rxonly();
    t_idle_low();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", cyc, 0);
      summary();
      $finish;
    end
  end
endmodule